// File: doc/BRIEF.md
# Packet Crossbar Switch Fabric with Input Queues

This block joins N ingress ports to N egress ports through a grid of crosspoints. Several connections can be open at once, so a full permutation of inputs to outputs moves in parallel, one word per port per cycle. Each ingress port has a small word FIFO in front of the grid. The destination given with the first word of a packet steers the whole packet.

Every egress port has its own round-robin arbiter. When several inputs want the same egress port, one of them gets the crosspoint. The others wait in their FIFOs. A crosspoint closes when an input's head word is first shown to the egress port. It stays closed until the word marked last has been accepted, so packets are never interleaved and never preempted. An input whose head packet cannot get through also holds back every packet queued behind it. Each egress port has a ready signal for backpressure. The fabric does not look up addresses and does not queue traffic at the egress side.

Top module: `xbar_fabric`

## Requirements
- R1: While reset is held and after it is released with no traffic, every `out_valid_o` bit is 0 and every `in_ready_o` bit is 1.
- R2: Any input can reach any output. With inputs 0..4 sending to outputs 0,2,4,1,3, all N outputs are valid in the same cycle, and every output delivers its own input's words.
- R3: A word written to an empty input whose destination output is free is valid at that output in the cycle after the write edge.
- R4: When several inputs target one output, one packet is delivered whole, from its first word through its last, before any word of another packet reaches that output.
- R5: After reset, input 0 has the highest priority. After a packet ends, the highest priority passes to the input just after the one that sent that packet, in cyclic order. Two single-word packets that arrive together at output 3 from inputs 0 and 4, after a packet from input 2, leave from input 4 first.
- R6: While an output is valid and its ready is 0, its data and valid do not change.
- R7: When an input's head packet is blocked, the packets behind it in that input's FIFO stay queued, even if their output is free.
- R8: After DEPTH words have entered an input's FIFO with none leaving, that input's `in_ready_o` is 0. A word offered while ready is 0 is dropped and never reaches an output.
- R9: The destination that is sampled with a packet's first word applies to all of its words. The `in_dest_i` value on later words is ignored. Destinations must be below N.
- R10: An output that has no crosspoint closed, or that is waiting on an empty input, drives `out_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N | Word offered on each input |
| in_data_i | input | N*W | Word data per input |
| in_last_i | input | N | Marks the last word of a packet |
| in_dest_i | input | N*clog2(N) | Destination output, sampled on the first word |
| in_ready_o | output | N | Input FIFO has room |
| out_valid_o | output | N | Word available on each output |
| out_data_o | output | N*W | Word data per output |
| out_last_o | output | N | Last word of the packet on each output |
| out_ready_i | input | N | Output accepts the word this cycle |

## Verification
The FIFO heads are registered and feed the outputs through the arbiter and the crosspoint mux with no further register. A word written at one edge is therefore visible at its output from the next falling edge, and it is consumed at the edge after that if ready is high. The bench drives inputs one time unit after a rising edge and samples outputs on falling edges. A monitor logs every accepted word on each output on each falling edge. Each check compares either the live outputs in the cycle they are due, or the order and count of logged words after a drain window that is longer than the number of words queued.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {ARB_IDLE, ARB_HOLD} arb_st_e;
endpackage

// File: rtl/xbar_in_fifo.sv
module xbar_in_fifo #(
  parameter int W     = 8,
  parameter int DW    = 3,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          push_last_i,
  input  logic [DW-1:0] push_dest_i,
  output logic          push_ready_o,
  output logic          head_valid_o,
  output logic [W-1:0]  head_data_o,
  output logic          head_last_o,
  output logic [DW-1:0] head_dest_o,
  input  logic          pop_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  data_q [DEPTH];
  logic          last_q [DEPTH];
  logic [DW-1:0] dest_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic          mid_q;        // write side is inside a packet
  logic [DW-1:0] lock_dest_q;
  logic          push, pop;
  logic [DW-1:0] eff_dest;

  assign push_ready_o = (count_q != CW'(DEPTH));
  assign head_valid_o = (count_q != '0);
  assign push         = push_valid_i && push_ready_o;
  assign pop          = pop_i && head_valid_o;
  assign eff_dest     = mid_q ? lock_dest_q : push_dest_i;

  assign head_data_o = data_q[rd_q];
  assign head_last_o = last_q[rd_q];
  assign head_dest_o = dest_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push) begin
      data_q[wr_q] <= push_data_i;
      last_q[wr_q] <= push_last_i;
      dest_q[wr_q] <= eff_dest;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= '0;
      rd_q        <= '0;
      count_q     <= '0;
      mid_q       <= 1'b0;
      lock_dest_q <= '0;
    end else begin
      if (push) begin
        wr_q  <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
        mid_q <= !push_last_i;
        if (!mid_q) lock_dest_q <= push_dest_i;
      end
      if (pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         fire_i,
  input  logic         last_i,
  output logic [N-1:0] sel_o
);
  import xbar_pkg::*;
  localparam int IW = $clog2(N);

  arb_st_e       st_q;
  logic [N-1:0]  owner_q, pick;
  logic [IW-1:0] ptr_q, sel_idx;

  // first requester after the last granted input, cyclic
  always_comb begin
    pick = '0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (pick == '0 && req_i[idx]) pick[idx] = 1'b1;
    end
  end

  assign sel_o = (st_q == ARB_HOLD) ? owner_q : pick;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < N; i++) if (sel_o[i]) sel_idx = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ARB_IDLE;
      owner_q <= '0;
      ptr_q   <= IW'(N - 1);
    end else if (fire_i && last_i) begin
      st_q  <= ARB_IDLE;
      ptr_q <= sel_idx;
    end else if (st_q == ARB_IDLE && pick != '0) begin
      st_q    <= ARB_HOLD;
      owner_q <= pick;
    end
  end
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric #(
  parameter int N     = 5,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         in_valid_i,
  input  logic [N-1:0][W-1:0]  in_data_i,
  input  logic [N-1:0]         in_last_i,
  input  logic [N-1:0][DW-1:0] in_dest_i,
  output logic [N-1:0]         in_ready_o,
  output logic [N-1:0]         out_valid_o,
  output logic [N-1:0][W-1:0]  out_data_o,
  output logic [N-1:0]         out_last_o,
  input  logic [N-1:0]         out_ready_i
);
  logic [N-1:0]         head_valid, head_last, pop;
  logic [N-1:0][W-1:0]  head_data;
  logic [N-1:0][DW-1:0] head_dest;
  logic [N-1:0][N-1:0]  req_m;   // [out][in]
  logic [N-1:0][N-1:0]  sel_m;   // [out][in], one-hot crosspoint select

  for (genvar i = 0; i < N; i++) begin : g_in
    xbar_in_fifo #(.W(W), .DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_valid_i(in_valid_i[i]), .push_data_i(in_data_i[i]),
      .push_last_i(in_last_i[i]),   .push_dest_i(in_dest_i[i]),
      .push_ready_o(in_ready_o[i]),
      .head_valid_o(head_valid[i]), .head_data_o(head_data[i]),
      .head_last_o(head_last[i]),   .head_dest_o(head_dest[i]),
      .pop_i(pop[i])
    );
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_req
      assign req_m[o][i] = head_valid[i] && (head_dest[i] == DW'(o));
    end

    xbar_rr_arb #(.N(N)) u_arb (
      .clk_i, .rst_ni,
      .req_i(req_m[o]),
      .fire_i(out_valid_o[o] && out_ready_i[o]),
      .last_i(out_last_o[o]),
      .sel_o(sel_m[o])
    );

    always_comb begin
      out_valid_o[o] = 1'b0;
      out_last_o[o]  = 1'b0;
      out_data_o[o]  = '0;
      for (int i = 0; i < N; i++) begin
        out_valid_o[o] = out_valid_o[o] | (sel_m[o][i] & head_valid[i]);
        out_last_o[o]  = out_last_o[o]  | (sel_m[o][i] & head_last[i]);
        out_data_o[o]  = out_data_o[o]  | (head_data[i] & {W{sel_m[o][i]}});
      end
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        if (sel_m[o][i] && out_ready_i[o]) pop[i] = 1'b1;
  end
endmodule

// File: rtl/xbar_fabric_chk.sv
module xbar_fabric_chk #(
  parameter int N = 5,
  parameter int W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N-1:0][N-1:0] sel_m,
  input logic [N-1:0]        out_valid_o,
  input logic [N-1:0][W-1:0] out_data_o,
  input logic [N-1:0]        out_last_o,
  input logic [N-1:0]        out_ready_i
);
  logic [N-1:0][N-1:0] col_m;  // [in][out]
  always_comb
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++) col_m[i][o] = sel_m[o][i];

  for (genvar o = 0; o < N; o++) begin : g_o
    p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel_m[o]));
    p_nopreempt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && out_ready_i[o] && !out_last_o[o]) |=> $stable(sel_m[o]));
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && !out_ready_i[o]) |=>
        (out_valid_o[o] && $stable(out_data_o[o]) && $stable(out_last_o[o])));
    p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_m[o] == '0) |-> !out_valid_o[o]);
  end

  for (genvar i = 0; i < N; i++) begin : g_i
    p_one_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col_m[i]));
  end
endmodule

bind xbar_fabric xbar_fabric_chk #(.N(N), .W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_m(sel_m),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .out_last_o(out_last_o), .out_ready_i(out_ready_i)
);

// File: tb/sim_xbar_fabric.sv
`timescale 1ns/1ps
module sim_xbar_fabric;
  localparam int N = 5, W = 8, DEPTH = 4, DW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]         in_valid = '0, in_last = '0, in_ready;
  logic [N-1:0][W-1:0]  in_data = '0;
  logic [N-1:0][DW-1:0] in_dest = '0;
  logic [N-1:0]         out_valid, out_last, out_ready = '0;
  logic [N-1:0][W-1:0]  out_data;

  int errors = 0, checks = 0;
  logic [W-1:0] log_d [N][256];
  logic         log_l [N][256];
  int           cnt [N];

  always #2.5 clk = ~clk;

  xbar_fabric #(.N(N), .W(W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_dest_i(in_dest), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready)
  );

  initial for (int o = 0; o < N; o++) cnt[o] = 0;

  always @(negedge clk)
    if (rst_n)
      for (int o = 0; o < N; o++)
        if (out_valid[o] && out_ready[o]) begin
          log_d[o][cnt[o]] = out_data[o];
          log_l[o][cnt[o]] = out_last[o];
          cnt[o] = cnt[o] + 1;
        end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int i, int d, logic [W-1:0] dat, bit lst);
    in_valid[i] = 1'b1; in_data[i] = dat; in_dest[i] = DW'(d); in_last[i] = lst;
    @(posedge clk); #1;
    in_valid[i] = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 5'h1f);
  endtask

  task automatic t_perm;
    int dst [N] = '{0, 2, 4, 1, 3};
    int b [N];
    for (int o = 0; o < N; o++) b[o] = cnt[o];
    out_ready = '0;
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 3; k++) push(i, dst[i], W'(16 * i + k), k == 2);
    out_ready = '1;
    @(negedge clk);
    chk(out_valid == '1, "R2", "all outputs valid together", out_valid, 5'h1f);
    for (int i = 0; i < N; i++)
      chk(out_data[dst[i]] == W'(16 * i), "R2", "first word per output",
          out_data[dst[i]], 16 * i);
    wait_cyc(6);
    for (int i = 0; i < N; i++) begin
      int o = dst[i];
      chk(cnt[o] - b[o] == 3, "R2", "words per output", cnt[o] - b[o], 3);
      chk(log_d[o][b[o] + 2] == W'(16 * i + 2) && log_l[o][b[o] + 2], "R2",
          "third word and last", log_d[o][b[o] + 2], 16 * i + 2);
    end
  endtask

  task automatic t_contend;
    int b = cnt[3];
    out_ready = '0;
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < 2; k++) push(i, 3, W'(8'h80 + 16 * i + k), k == 1);
    out_ready = '1;
    @(negedge clk);
    chk((out_valid & ~5'b01000) == '0, "R10", "idle outputs low", out_valid, 0);
    wait_cyc(10);
    chk(cnt[3] - b == 6, "R4", "contended word count", cnt[3] - b, 6);
    for (int j = 0; j < 6; j++) begin
      int e = 8'h80 + 16 * (j / 2) + (j % 2);
      chk(log_d[3][b + j] == W'(e) && log_l[3][b + j] == (j % 2 == 1), "R4",
          "packet order, no interleave", log_d[3][b + j], e);
    end
  endtask

  task automatic t_rr;
    int b = cnt[3];
    out_ready = '0;
    in_valid[0] = 1'b1; in_data[0] = 8'hC0; in_dest[0] = 3'd3; in_last[0] = 1'b1;
    in_valid[4] = 1'b1; in_data[4] = 8'hC4; in_dest[4] = 3'd3; in_last[4] = 1'b1;
    @(posedge clk); #1;
    in_valid = '0;
    @(negedge clk);
    chk(out_valid[3] && out_data[3] == 8'hC4, "R5", "round-robin winner",
        out_data[3], 8'hC4);
    out_ready = '1;
    wait_cyc(4);
    chk(cnt[3] - b == 2 && log_d[3][b] == 8'hC4 && log_d[3][b + 1] == 8'hC0,
        "R5", "round-robin order", log_d[3][b + 1], 8'hC0);
  endtask

  task automatic t_hol;
    int b2 = cnt[2], b4 = cnt[4];
    logic [W-1:0] d0;
    out_ready = 5'b10000;
    push(1, 2, 8'h51, 1'b1);
    push(1, 4, 8'h52, 1'b1);
    push(3, 4, 8'h53, 1'b1);
    wait_cyc(3);
    chk(cnt[4] - b4 == 1 && log_d[4][b4] == 8'h53, "R7", "free input passes",
        log_d[4][b4], 8'h53);
    @(negedge clk);
    chk(!out_valid[4], "R7", "blocked packet held behind head", out_valid[4], 0);
    d0 = out_data[2];
    @(negedge clk);
    chk(out_valid[2] && out_data[2] == d0 && d0 == 8'h51, "R6",
        "stalled output stable", out_data[2], 8'h51);
    @(posedge clk); #1;
    out_ready[2] = 1'b1;
    wait_cyc(4);
    chk(cnt[2] - b2 == 1 && log_d[2][b2] == 8'h51, "R7", "head drains",
        log_d[2][b2], 8'h51);
    chk(cnt[4] - b4 == 2 && log_d[4][b4 + 1] == 8'h52, "R7", "queued follows",
        log_d[4][b4 + 1], 8'h52);
  endtask

  task automatic t_dest_lock;
    int b1 = cnt[1], b3 = cnt[3];
    out_ready = '1;
    push(2, 1, 8'h61, 1'b0);
    @(negedge clk);
    chk(out_valid[1] && out_data[1] == 8'h61, "R3", "one-cycle head latency",
        out_data[1], 8'h61);
    @(posedge clk); #1;
    push(2, 3, 8'h62, 1'b1);
    wait_cyc(3);
    chk(cnt[1] - b1 == 2 && log_d[1][b1 + 1] == 8'h62, "R9",
        "later dest ignored", cnt[1] - b1, 2);
    chk(cnt[3] - b3 == 0, "R9", "no word on later dest", cnt[3] - b3, 0);
  endtask

  task automatic t_full;
    int b = cnt[0];
    out_ready = '0;
    for (int k = 0; k < DEPTH; k++) push(0, 0, W'(8'h40 + k), 1'b0);
    @(negedge clk);
    chk(!in_ready[0], "R8", "ready low when full", in_ready[0], 0);
    @(posedge clk); #1;
    in_valid[0] = 1'b1; in_data[0] = 8'hEE; in_last[0] = 1'b0;
    @(posedge clk); #1;
    in_valid[0] = 1'b0;
    out_ready[0] = 1'b1;
    wait_cyc(6);
    push(0, 0, 8'h44, 1'b1);
    wait_cyc(3);
    chk(cnt[0] - b == DEPTH + 1, "R8", "dropped word absent", cnt[0] - b, DEPTH + 1);
    chk(log_d[0][b + DEPTH - 1] == 8'h43 && log_d[0][b + DEPTH] == 8'h44
        && log_l[0][b + DEPTH], "R8", "sequence after full",
        log_d[0][b + DEPTH], 8'h44);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    @(posedge clk); #1;
    t_perm();
    t_contend();
    t_rr();
    t_hol();
    t_dest_lock();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule